// File: doc/BRIEF.md
# Dual-Bank Clock Divider Register Loader

This block holds the programming state for a clock generator that has two ways of setting its frequency: a pair of 24-bit ratio registers for a numerically controlled oscillator, and a pair of 11-bit integer dividers for a PLL. Both pairs sit behind the same host byte addresses. A 2-bit load mode in a control register decides which pair a host write reaches. In two of the four modes, the pair that is not written is also reset to a fixed preset, so that one write sequence leaves the whole generator in a known state.

Each 24-bit value takes up three consecutive byte addresses, with the least significant byte at the lowest address. The two lower bytes go into a staging register. The value moves into the selected bank only when the top byte is written, so the synthesis logic downstream never sees a half-written ratio. The block also holds a second control register that carries a clock-halving enable and a pad power-down control. It drives the effective PLL divide values, which are the stored M plus two and the stored N plus one. Reads are combinational from the address. A read of the shared address returns the bank that the current mode selects.

Top module: `divsel_loader`

## Requirements
- R1: After reset the load mode is 0, the ratio numerator and denominator are both 50, M is 512, N is 128, and both bits of the second control register are 0.
- R2: A write to the mode register (address 0x08) takes load mode from data bits 5:4. A read of that address returns the mode in bits 5:4, and all other bits read as 0.
- R3: In mode 0, committing a value to the numerator (0x00..0x02) or denominator (0x04..0x06) address updates that ratio register only. M and N do not change.
- R4: In mode 1, a commit to the numerator address loads M with the low 11 bits of the value, and a commit to the denominator address loads N the same way. The ratio registers do not change.
- R5: In mode 2, a commit updates the addressed ratio register and also sets M to 512 and N to 128.
- R6: In mode 3, a commit loads M or N from the low 11 bits and also sets both ratio registers to 50.
- R7: A write to the lowest or middle byte of a 24-bit value changes no output. The staged value moves to its bank in the cycle after the top byte is written.
- R8: The effective divide outputs always equal stored M plus 2 and stored N plus 1.
- R9: The second control register (address 0x09) holds the clock-halving enable in bit 1 and the pad power-down in bit 7. All other bits read as 0.
- R10: A read of a numerator or denominator byte returns the ratio register in modes 0 and 2, and M or N zero-extended to 24 bits in modes 1 and 3.
- R11: Writes to addresses outside the map change no state, and reads of them return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Byte write strobe |
| addr | input | 8 | Byte address for writes and reads |
| wdata | input | 8 | Write data byte |
| rd_data | output | 8 | Combinational read data for addr |
| nco_num | output | 24 | Oscillator ratio numerator |
| nco_den | output | 24 | Oscillator ratio denominator |
| pll_m | output | 11 | Stored PLL M field |
| pll_n | output | 11 | Stored PLL N field |
| m_divide | output | 12 | Effective M divide (M+2) |
| n_divide | output | 12 | Effective N divide (N+1) |
| clk_half_en | output | 1 | Clock halving enable |
| pad_pwrdn | output | 1 | Pad power-down control |

## Verification
The hardest case to reach is a commit whose effect depends on a mode chosen earlier, in a bank that is not being written: that is, the presets forced in modes 2 and 3. To reach it, the stimulus first moves both banks away from their presets. It then switches mode and commits, so that a forced value shows up as a visible change. The stimulus also leaves a lower byte staged across a mode change and checks that nothing moves until a top byte arrives. Reads taken in each mode confirm that the view of the shared address follows the mode.

// File: rtl/divsel_pkg.sv
package divsel_pkg;
    localparam int VAL_W  = 24;
    localparam int DIV_W  = 11;
    localparam int BYTE_W = 8;
    localparam int NBYTES = VAL_W / BYTE_W;

    localparam logic [DIV_W-1:0] M_PRESET   = DIV_W'(512);
    localparam logic [DIV_W-1:0] N_PRESET   = DIV_W'(128);
    localparam logic [VAL_W-1:0] NCO_PRESET = VAL_W'(50);

    typedef enum logic [1:0] {
        LM_NCO     = 2'd0,
        LM_PLL     = 2'd1,
        LM_NCO_PRE = 2'd2,
        LM_PLL_PRE = 2'd3
    } load_mode_e;

    typedef struct packed {
        load_mode_e       mode;
        logic             clk_half;
        logic             pad_pd;
        logic [VAL_W-1:0] num;
        logic [VAL_W-1:0] den;
        logic [DIV_W-1:0] m;
        logic [DIV_W-1:0] n;
    } regs_t;
endpackage

// File: rtl/divsel_stage.sv
module divsel_stage
    import divsel_pkg::*;
#(
    parameter int                ADDR_W = 8,
    parameter logic [ADDR_W-1:0] BASE   = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [BYTE_W-1:0] wdata,
    output logic              commit,
    output logic [VAL_W-1:0]  value
);
    localparam int LOW_W = VAL_W - BYTE_W;
    localparam logic [ADDR_W-1:0] TOP_ADDR = BASE + ADDR_W'(NBYTES - 1);

    logic [LOW_W-1:0] stage_d, stage_q;

    always_comb begin
        stage_d = stage_q;
        for (int b = 0; b < NBYTES - 1; b++) begin
            if (wr_en && addr == BASE + ADDR_W'(b)) begin
                stage_d[b*BYTE_W +: BYTE_W] = wdata;
            end
        end
        commit = wr_en && (addr == TOP_ADDR);
        value  = {wdata, stage_q};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q <= '0;
        else        stage_q <= stage_d;
    end
endmodule

// File: rtl/divsel_rdmux.sv
module divsel_rdmux
    import divsel_pkg::*;
#(
    parameter int                ADDR_W    = 8,
    parameter logic [ADDR_W-1:0] NUM_BASE  = 8'h00,
    parameter logic [ADDR_W-1:0] DEN_BASE  = 8'h04,
    parameter logic [ADDR_W-1:0] MODE_ADDR = 8'h08,
    parameter logic [ADDR_W-1:0] MISC_ADDR = 8'h09
) (
    input  logic [ADDR_W-1:0] addr,
    input  regs_t             st,
    output logic [BYTE_W-1:0] rd_data
);
    logic             show_pll;
    logic [VAL_W-1:0] num_view, den_view;

    always_comb begin
        show_pll = st.mode[0];
        num_view = show_pll ? VAL_W'(st.m) : st.num;
        den_view = show_pll ? VAL_W'(st.n) : st.den;
        rd_data  = '0;
        for (int b = 0; b < NBYTES; b++) begin
            if (addr == NUM_BASE + ADDR_W'(b)) rd_data = num_view[b*BYTE_W +: BYTE_W];
            if (addr == DEN_BASE + ADDR_W'(b)) rd_data = den_view[b*BYTE_W +: BYTE_W];
        end
        if (addr == MODE_ADDR) rd_data = {2'b00, st.mode, 4'b0000};
        if (addr == MISC_ADDR) rd_data = {st.pad_pd, 5'b00000, st.clk_half, 1'b0};
    end
endmodule

// File: rtl/divsel_loader.sv
module divsel_loader
    import divsel_pkg::*;
#(
    parameter int                ADDR_W    = 8,
    parameter logic [ADDR_W-1:0] NUM_BASE  = 8'h00,
    parameter logic [ADDR_W-1:0] DEN_BASE  = 8'h04,
    parameter logic [ADDR_W-1:0] MODE_ADDR = 8'h08,
    parameter logic [ADDR_W-1:0] MISC_ADDR = 8'h09
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [7:0]        wdata,
    output logic [7:0]        rd_data,
    output logic [23:0]       nco_num,
    output logic [23:0]       nco_den,
    output logic [10:0]       pll_m,
    output logic [10:0]       pll_n,
    output logic [11:0]       m_divide,
    output logic [11:0]       n_divide,
    output logic              clk_half_en,
    output logic              pad_pwrdn
);
    localparam int NPAIR = 2;  // index 0 numerator/M, 1 denominator/N

    regs_t            st_d, st_q;
    logic [NPAIR-1:0] commit;
    logic [VAL_W-1:0] value [NPAIR];

    for (genvar g = 0; g < NPAIR; g++) begin : g_pair
        localparam logic [ADDR_W-1:0] PBASE = (g == 0) ? NUM_BASE : DEN_BASE;
        divsel_stage #(.ADDR_W(ADDR_W), .BASE(PBASE)) u_stage (
            .clk    (clk),
            .rst_n  (rst_n),
            .wr_en  (wr_en),
            .addr   (addr),
            .wdata  (wdata),
            .commit (commit[g]),
            .value  (value[g])
        );
    end

    always_comb begin
        st_d = st_q;
        if (wr_en && addr == MODE_ADDR) st_d.mode = load_mode_e'(wdata[5:4]);
        if (wr_en && addr == MISC_ADDR) begin
            st_d.clk_half = wdata[1];
            st_d.pad_pd   = wdata[7];
        end
        for (int p = 0; p < NPAIR; p++) begin
            if (commit[p]) begin
                unique case (st_q.mode)
                    LM_NCO, LM_NCO_PRE: begin
                        if (p == 0) st_d.num = value[p];
                        else        st_d.den = value[p];
                        if (st_q.mode == LM_NCO_PRE) begin
                            st_d.m = M_PRESET;
                            st_d.n = N_PRESET;
                        end
                    end
                    LM_PLL, LM_PLL_PRE: begin
                        if (p == 0) st_d.m = value[p][DIV_W-1:0];
                        else        st_d.n = value[p][DIV_W-1:0];
                        if (st_q.mode == LM_PLL_PRE) begin
                            st_d.num = NCO_PRESET;
                            st_d.den = NCO_PRESET;
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.mode     <= LM_NCO;
            st_q.clk_half <= 1'b0;
            st_q.pad_pd   <= 1'b0;
            st_q.num      <= NCO_PRESET;
            st_q.den      <= NCO_PRESET;
            st_q.m        <= M_PRESET;
            st_q.n        <= N_PRESET;
        end else begin
            st_q <= st_d;
        end
    end

    divsel_rdmux #(
        .ADDR_W(ADDR_W), .NUM_BASE(NUM_BASE), .DEN_BASE(DEN_BASE),
        .MODE_ADDR(MODE_ADDR), .MISC_ADDR(MISC_ADDR)
    ) u_rdmux (
        .addr    (addr),
        .st      (st_q),
        .rd_data (rd_data)
    );

    assign nco_num     = st_q.num;
    assign nco_den     = st_q.den;
    assign pll_m       = st_q.m;
    assign pll_n       = st_q.n;
    assign m_divide    = {1'b0, st_q.m} + 12'd2;
    assign n_divide    = {1'b0, st_q.n} + 12'd1;
    assign clk_half_en = st_q.clk_half;
    assign pad_pwrdn   = st_q.pad_pd;
endmodule

// File: rtl/divsel_chk.sv
module divsel_chk #(
    parameter int                ADDR_W   = 8,
    parameter logic [ADDR_W-1:0] NUM_BASE = 8'h00,
    parameter logic [ADDR_W-1:0] DEN_BASE = 8'h04
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic [ADDR_W-1:0] addr,
    input logic [1:0]        mode,
    input logic [23:0]       num,
    input logic [23:0]       den,
    input logic [10:0]       m,
    input logic [10:0]       n
);
    logic num_top, den_top, any_top;
    assign num_top = wr_en && (addr == NUM_BASE + ADDR_W'(2));
    assign den_top = wr_en && (addr == DEN_BASE + ADDR_W'(2));
    assign any_top = num_top || den_top;

    assert_pll_kept_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (any_top && mode == 2'd0) |=> ($stable(m) && $stable(n)));

    assert_nco_kept_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (any_top && mode == 2'd1) |=> ($stable(num) && $stable(den)));

    assert_pll_preset_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (any_top && mode == 2'd2) |=> (m == 11'd512 && n == 11'd128));

    assert_nco_preset_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (any_top && mode == 2'd3) |=> (num == 24'd50 && den == 24'd50));

    assert_no_partial_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !any_top) |=> ($stable(num) && $stable(den) && $stable(m) && $stable(n)));
endmodule

bind divsel_loader divsel_chk #(
    .ADDR_W(ADDR_W), .NUM_BASE(NUM_BASE), .DEN_BASE(DEN_BASE)
) u_chk (
    .clk   (clk),
    .rst_n (rst_n),
    .wr_en (wr_en),
    .addr  (addr),
    .mode  (st_q.mode),
    .num   (nco_num),
    .den   (nco_den),
    .m     (pll_m),
    .n     (pll_n)
);

// File: tb/sim_divsel_loader.sv
module sim_divsel_loader;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [7:0]  addr = '0;
    logic [7:0]  wdata = '0;
    logic [7:0]  rd_data;
    logic [23:0] nco_num, nco_den;
    logic [10:0] pll_m, pll_n;
    logic [11:0] m_divide, n_divide;
    logic        clk_half_en, pad_pwrdn;

    always #2 clk = ~clk;

    divsel_loader u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
        .rd_data(rd_data), .nco_num(nco_num), .nco_den(nco_den),
        .pll_m(pll_m), .pll_n(pll_n), .m_divide(m_divide), .n_divide(n_divide),
        .clk_half_en(clk_half_en), .pad_pwrdn(pad_pwrdn)
    );

    typedef struct {
        int          kind;
        logic [31:0] exp;
        string       req;
    } item_t;
    item_t q[$];

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    // reference model built from the requirements
    logic [23:0] e_num = 24'd50, e_den = 24'd50;
    logic [10:0] e_m = 11'd512, e_n = 11'd128;
    logic [1:0]  e_mode = 2'd0;
    logic        e_ch = 1'b0, e_pd = 1'b0;
    logic [15:0] e_nst = '0, e_dst = '0;

    function automatic logic [31:0] actual(int kind);
        case (kind)
            0: return 32'(nco_num);
            1: return 32'(nco_den);
            2: return 32'(pll_m);
            3: return 32'(pll_n);
            4: return 32'(m_divide);
            5: return 32'(n_divide);
            6: return 32'(clk_half_en);
            7: return 32'(pad_pwrdn);
            default: return 32'(rd_data);
        endcase
    endfunction

    always @(negedge clk) begin
        while (q.size() > 0) begin
            item_t it;
            logic [31:0] act;
            it  = q.pop_front();
            act = actual(it.kind);
            checks++;
            if (act !== it.exp) begin
                fails++;
                $display("FAIL %s kind=%0d actual=%0h expected=%0h", it.req, it.kind, act, it.exp);
            end
        end
    end

    task automatic push(int kind, logic [31:0] exp, string req);
        item_t it;
        it.kind = kind; it.exp = exp; it.req = req;
        q.push_back(it);
    endtask

    task automatic check_all(string req);
        push(0, 32'(e_num), req);
        push(1, 32'(e_den), req);
        push(2, 32'(e_m), req);
        push(3, 32'(e_n), req);
        push(4, 32'(e_m) + 2, {req, "/R8"});
        push(5, 32'(e_n) + 1, {req, "/R8"});
        push(6, 32'(e_ch), req);
        push(7, 32'(e_pd), req);
    endtask

    function automatic void model_wr(logic [7:0] a, logic [7:0] d);
        logic [23:0] v;
        if (a == 8'h08) e_mode = d[5:4];
        if (a == 8'h09) begin e_ch = d[1]; e_pd = d[7]; end
        if (a == 8'h00) e_nst[7:0]  = d;
        if (a == 8'h01) e_nst[15:8] = d;
        if (a == 8'h04) e_dst[7:0]  = d;
        if (a == 8'h05) e_dst[15:8] = d;
        if (a == 8'h02 || a == 8'h06) begin
            v = (a == 8'h02) ? {d, e_nst} : {d, e_dst};
            if (e_mode == 2'd0 || e_mode == 2'd2) begin
                if (a == 8'h02) e_num = v; else e_den = v;
                if (e_mode == 2'd2) begin e_m = 11'd512; e_n = 11'd128; end
            end else begin
                if (a == 8'h02) e_m = v[10:0]; else e_n = v[10:0];
                if (e_mode == 2'd3) begin e_num = 24'd50; e_den = 24'd50; end
            end
        end
    endfunction

    task automatic wr(logic [7:0] a, logic [7:0] d);
        @(posedge clk); #1;
        wr_en = 1'b1; addr = a; wdata = d;
        @(posedge clk); #1;
        wr_en = 1'b0;
        model_wr(a, d);
    endtask

    task automatic rd(logic [7:0] a, logic [7:0] exp, string req);
        @(posedge clk); #1;
        wr_en = 1'b0; addr = a;
        push(8, 32'(exp), req);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        check_all("R1");
        rd(8'h08, 8'h00, "R1");
        rd(8'h09, 8'h00, "R1");
        rd(8'h00, 8'h32, "R10 mode0 reads ratio");

        // R7: lower bytes staged, nothing moves
        wr(8'h00, 8'h11); wr(8'h01, 8'h22); check_all("R7");
        wr(8'h02, 8'h33); check_all("R3");
        wr(8'h04, 8'h44); wr(8'h05, 8'h55); wr(8'h06, 8'h66); check_all("R3");
        rd(8'h04, 8'h44, "R10"); rd(8'h05, 8'h55, "R10"); rd(8'h06, 8'h66, "R10");

        // R2: mode field
        wr(8'h08, 8'hFF); rd(8'h08, 8'h30, "R2");
        wr(8'h08, 8'h10); rd(8'h08, 8'h10, "R2");

        // mode 1
        wr(8'h00, 8'hFF); wr(8'h01, 8'hC7); wr(8'h02, 8'hAB); check_all("R4");
        wr(8'h04, 8'h56); wr(8'h05, 8'h34); wr(8'h06, 8'h12); check_all("R4");
        push(4, 32'h801, "R8"); push(5, 32'h457, "R8");
        rd(8'h00, 8'hFF, "R10"); rd(8'h01, 8'h07, "R10"); rd(8'h02, 8'h00, "R10");
        rd(8'h04, 8'h56, "R10"); rd(8'h05, 8'h04, "R10");

        // mode 2
        wr(8'h08, 8'h20);
        wr(8'h00, 8'h77); wr(8'h01, 8'h07); wr(8'h02, 8'h00); check_all("R5");
        push(2, 32'd512, "R5"); push(3, 32'd128, "R5"); push(4, 32'd514, "R8");
        rd(8'h00, 8'h77, "R10"); rd(8'h01, 8'h07, "R10");

        // mode 3
        wr(8'h08, 8'h30);
        wr(8'h04, 8'h0A); wr(8'h05, 8'h00); wr(8'h06, 8'h00); check_all("R6");
        push(0, 32'd50, "R6"); push(1, 32'd50, "R6"); push(3, 32'd10, "R6");
        rd(8'h04, 8'h0A, "R10");
        wr(8'h00, 8'h05); check_all("R7");

        // R9
        wr(8'h09, 8'hFF); check_all("R9"); rd(8'h09, 8'h82, "R9");
        wr(8'h09, 8'h02); check_all("R9"); rd(8'h09, 8'h02, "R9");

        // R11
        wr(8'h0F, 8'hFF); wr(8'h03, 8'hAA); check_all("R11");
        rd(8'h0F, 8'h00, "R11"); rd(8'h08, 8'h30, "R11");

        repeat (3) @(posedge clk);
        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog expired actual=hung expected=done");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end
endmodule